// File: doc/BRIEF.md
# Programmable Loss-of-Signal Detector

This block watches a recovered line bit stream. A clock enable marks one sample per pulse period. A sampled zero means that no pulse arrived in that period. When the zeros run on long enough, the block raises a loss-of-signal alarm. The length of that run is set by a detection value scaled by sixteen.

Once the alarm is up, it is removed only after a programmable number of pulses has been counted. The count comes from a second register, which gives the alarm hysteresis. Any run of zeros that again reaches the detection length starts the pulse count over.

The block sends its state to software through two outputs. The first is a live status bit. The second is a sticky interrupt request, with a mask and a one-cycle acknowledge. The interrupt can fire on alarm entry only, or on every change of status.

Top module: `los_monitor`

## Requirements
- R1: After a synchronous reset, los_alarm and irq_req are both 0.
- R2: los_alarm goes to 1 on the clock edge that samples the N-th consecutive zero of rx_bit, where N = det_len × 16 and a sample is taken only when bit_en is 1.
- R3: det_len = 0 selects N = 4096.
- R4: Any sampled one restarts the zero run, so a run cut short before reaching N raises no alarm.
- R5: While los_alarm is 1, it returns to 0 on the edge that samples the M-th one, where M = rec_len. The ones need not be consecutive, and zero runs shorter than N do not disturb the count.
- R6: rec_len = 0 selects M = 1.
- R7: While los_alarm is 1, a zero run that reaches N clears the pulse count, so M further ones are needed.
- R8: When irq_mask is 0, irq_req is set in the same cycle that los_alarm rises. When irq_mask is 1, irq_req is not set. los_alarm follows the alarm state whatever the mask.
- R9: When chg_mode is 1 and irq_mask is 0, irq_req is also set in the cycle that los_alarm falls. When chg_mode is 0, a fall sets nothing.
- R10: irq_req holds until a cycle with irq_ack = 1 clears it. A set event in the same cycle as the acknowledge wins.
- R11: Cycles with bit_en = 0 leave all counters and the alarm unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One cycle per pulse period; qualifies rx_bit |
| rx_bit | input | 1 | Sampled line bit; 1 = pulse, 0 = no pulse |
| det_len | input | 8 | Detection length in units of 16 periods; 0 = 256 units |
| rec_len | input | 8 | Pulses needed to clear the alarm; 0 = 1 |
| irq_mask | input | 1 | 1 blocks the setting of irq_req |
| chg_mode | input | 1 | 1 = interrupt on both alarm edges; 0 = on rise only |
| irq_ack | input | 1 | One-cycle clear of irq_req |
| los_alarm | output | 1 | Current alarm state |
| irq_req | output | 1 | Sticky interrupt request |

## Verification
The bench places a single one just before the N-th zero. A design that failed to restart the count would raise a false alarm. It also feeds the full 4096-period run with det_len at zero: a design that took the zero literally would alarm at once or never. For recovery, a long zero run is inserted between pulses. A design that skipped the count reset would clear one pulse early. The bench drives an acknowledge into the same cycle as a set event: a design that let the acknowledge win would lose that interrupt. It also holds the enable low with zeros present, which would make a design without gating alarm early.

// File: rtl/los_monitor.sv
module los_monitor #(
  parameter int DET_W      = 8,
  parameter int REC_W      = 8,
  parameter int SCALE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic [DET_W-1:0] det_len,
  input  logic [REC_W-1:0] rec_len,
  input  logic             irq_mask,
  input  logic             chg_mode,
  input  logic             irq_ack,
  output logic             los_alarm,
  output logic             irq_req
);
  localparam int CNT_W = DET_W + 1 + SCALE_LOG2;

  logic [CNT_W-1:0] zero_cnt;
  logic [REC_W-1:0] pulse_cnt;

  wire [DET_W:0]     det_eff   = (det_len == '0) ? {1'b1, {DET_W{1'b0}}} : {1'b0, det_len};
  wire [CNT_W-1:0]   limit     = {det_eff, {SCALE_LOG2{1'b0}}};
  wire [CNT_W-1:0]   zero_inc  = zero_cnt + 1'b1;
  wire [REC_W-1:0]   rec_eff   = (rec_len == '0) ? REC_W'(1) : rec_len;
  wire [REC_W:0]     pulse_inc = {1'b0, pulse_cnt} + 1'b1;

  wire hit    = bit_en & ~rx_bit & (zero_inc >= limit);
  wire done   = los_alarm & bit_en & rx_bit & (pulse_inc >= {1'b0, rec_eff});
  wire set_ev = hit & ~los_alarm;
  wire irq_ev = ~irq_mask & (set_ev | (done & chg_mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_cnt  <= '0;
      pulse_cnt <= '0;
      los_alarm <= 1'b0;
      irq_req   <= 1'b0;
    end else begin
      if (bit_en)
        zero_cnt <= rx_bit ? '0 : (hit ? limit : zero_inc);

      if (!los_alarm || hit || done)
        pulse_cnt <= '0;
      else if (bit_en && rx_bit)
        pulse_cnt <= pulse_inc[REC_W-1:0];

      if (set_ev)
        los_alarm <= 1'b1;
      else if (done)
        los_alarm <= 1'b0;

      if (irq_ev)
        irq_req <= 1'b1;
      else if (irq_ack)
        irq_req <= 1'b0;
    end
  end
endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic rx_bit,
  input logic irq_mask,
  input logic chg_mode,
  input logic irq_ack,
  input logic los_alarm,
  input logic irq_req
);
  a_r2_rise_on_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(los_alarm) |-> $past(bit_en && !rx_bit));

  a_r5_fall_on_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(los_alarm) |-> $past(bit_en && rx_bit));

  a_r11_hold_no_en: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> $stable(los_alarm));

  a_r8_irq_unmasked: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(!irq_mask));

  a_r8_irq_with_rise: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_req) && los_alarm) |-> $rose(los_alarm));

  a_r9_irq_on_clear: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_req) && !los_alarm) |-> ($fell(los_alarm) && $past(chg_mode)));

  a_r10_fall_needs_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_req) |-> $past(irq_ack));
endmodule

bind los_monitor los_monitor_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
  .irq_mask(irq_mask), .chg_mode(chg_mode), .irq_ack(irq_ack),
  .los_alarm(los_alarm), .irq_req(irq_req)
);

// File: tb/los_monitor_tb.sv
module los_monitor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, rx_bit = 1'b0;
  logic [7:0] det_len = 8'd1, rec_len = 8'd1;
  logic irq_mask = 1'b0, chg_mode = 1'b0, irq_ack = 1'b0;
  logic los_alarm, irq_req;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  los_monitor u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .det_len(det_len), .rec_len(rec_len), .irq_mask(irq_mask),
    .chg_mode(chg_mode), .irq_ack(irq_ack),
    .los_alarm(los_alarm), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send(input logic b, input logic a);
    @(negedge clk);
    rx_bit = b; bit_en = 1'b1; irq_ack = a;
    @(negedge clk);
    bit_en = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic run(input int n, input logic b);
    for (int i = 0; i < n; i++) send(b, 1'b0);
  endtask

  task automatic do_ack;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 alarm after reset", los_alarm, 1'b0);
    check("R1 irq after reset", irq_req, 1'b0);
  endtask

  task automatic t_detect;
    do_reset(); det_len = 8'd2; irq_mask = 1'b0;
    run(31, 1'b0);
    check("R2 no alarm at N-1", los_alarm, 1'b0);
    @(negedge clk); rx_bit = 1'b0;
    repeat (10) @(negedge clk);
    check("R11 idle cycles ignored", los_alarm, 1'b0);
    send(1'b0, 1'b0);
    check("R2 alarm at N", los_alarm, 1'b1);
    check("R8 irq on entry", irq_req, 1'b1);
    repeat (5) @(negedge clk);
    check("R10 irq held", irq_req, 1'b1);
    do_ack();
    check("R10 ack clears", irq_req, 1'b0);
  endtask

  task automatic t_break;
    do_reset(); det_len = 8'd1;
    run(15, 1'b0); send(1'b1, 1'b0); run(15, 1'b0);
    check("R4 one restarts run", los_alarm, 1'b0);
    send(1'b0, 1'b0);
    check("R4 full run alarms", los_alarm, 1'b1);
  endtask

  task automatic t_recover;
    do_ack(); chg_mode = 1'b0; rec_len = 8'd3;
    send(1'b1, 1'b0);
    run(5, 1'b0);
    send(1'b1, 1'b0);
    check("R5 alarm held before M", los_alarm, 1'b1);
    send(1'b1, 1'b0);
    check("R5 clear at M", los_alarm, 1'b0);
    check("R9 no irq on clear", irq_req, 1'b0);
  endtask

  task automatic t_rec_zero;
    do_reset(); det_len = 8'd1; rec_len = 8'd0; chg_mode = 1'b1;
    run(16, 1'b0);
    check("R6 alarm set", los_alarm, 1'b1);
    do_ack();
    send(1'b1, 1'b0);
    check("R6 one pulse clears", los_alarm, 1'b0);
    check("R9 irq on clear", irq_req, 1'b1);
    do_ack();
    chg_mode = 1'b0;
  endtask

  task automatic t_rerun;
    do_reset(); det_len = 8'd1; rec_len = 8'd2;
    run(16, 1'b0); do_ack();
    send(1'b1, 1'b0);
    run(16, 1'b0);
    check("R7 alarm still set", los_alarm, 1'b1);
    check("R7 no new irq", irq_req, 1'b0);
    send(1'b1, 1'b0);
    check("R7 count restarted", los_alarm, 1'b1);
    send(1'b1, 1'b0);
    check("R7 clears after M more", los_alarm, 1'b0);
  endtask

  task automatic t_mask;
    do_reset(); det_len = 8'd1; rec_len = 8'd1; irq_mask = 1'b1; chg_mode = 1'b1;
    run(16, 1'b0);
    check("R8 status despite mask", los_alarm, 1'b1);
    check("R8 masked no irq", irq_req, 1'b0);
    send(1'b1, 1'b0);
    check("R8 status clears", los_alarm, 1'b0);
    check("R9 masked no clear irq", irq_req, 1'b0);
    irq_mask = 1'b0; chg_mode = 1'b0;
  endtask

  task automatic t_prio;
    do_reset(); det_len = 8'd1;
    run(15, 1'b0);
    send(1'b0, 1'b1);
    check("R10 set beats ack", irq_req, 1'b1);
    do_ack();
    check("R10 later ack clears", irq_req, 1'b0);
  endtask

  task automatic t_det0;
    do_reset(); det_len = 8'd0;
    run(4095, 1'b0);
    check("R3 no alarm at 4095", los_alarm, 1'b0);
    send(1'b0, 1'b0);
    check("R3 alarm at 4096", los_alarm, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_detect();
    t_break();
    t_recover();
    t_rec_zero();
    t_rerun();
    t_mask();
    t_prio();
    t_det0();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule